// File: doc/BRIEF.md
# Long Packet Length Sequencer

This block lets a packet engine send packets whose length does not fit in an 8-bit length field. On a start pulse it takes a 16-bit total length. Packets shorter than 256 bytes run in bounded (fixed) mode from the start. Longer packets begin in unbounded (infinite) mode. The 8-bit length value is loaded with the total modulo 256. The framer reports each transmitted byte with a one-cycle strobe.

An 8-bit wrapping byte counter and a 16-bit remaining-bytes down-counter advance on every strobe. When fewer than 256 bytes remain, the mode output switches to bounded. The packet ends on the strobe that brings the wrapping counter to the programmed length value. At that point a one-cycle done pulse is raised and the block returns to idle.

Top module: `pkt_len_ctrl`

## Requirements
- R1: After reset, `busy_o`, `fixed_mode_o`, `done_o` and `err_o` are 0, and `prog_len_o` and `byte_cnt_o` are 0.
- R2: A start in idle with a total from 1 to 255 gives `busy_o`=1, `fixed_mode_o`=1, `prog_len_o`=total and `byte_cnt_o`=0 on the next cycle.
- R3: A start in idle with a total of 256 or more gives `busy_o`=1, `fixed_mode_o`=0 (unbounded), `prog_len_o`=total mod 256 and `byte_cnt_o`=0 on the next cycle.
- R4: While busy, each `byte_sent_i` strobe advances `byte_cnt_o` by one modulo 256, so 255 is followed by 0.
- R5: While busy, `fixed_mode_o` is 1 exactly when fewer than 256 bytes remain. After the k-th strobe this is the case when total−k < 256.
- R6: The strobe that makes the sent count equal the total produces `done_o`=1 for exactly one cycle on the next cycle. In that same cycle `busy_o` falls and `byte_cnt_o` equals `prog_len_o`.
- R7: In idle, `byte_sent_i` has no effect: `byte_cnt_o` holds and `done_o` stays 0.
- R8: A start with a total of 0 leaves the block idle and pulses `err_o` for one cycle.
- R9: A start while busy is ignored: `prog_len_o`, the mode and the byte sequence are unaffected.
- R10: Once a packet has entered bounded mode, `fixed_mode_o` stays 1 until the packet ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| total_len_i | input | 16 | Total packet length in bytes |
| byte_sent_i | input | 1 | One-cycle strobe per byte sent by the framer |
| busy_o | output | 1 | Packet in progress |
| fixed_mode_o | output | 1 | 1 = bounded length mode, 0 = unbounded |
| prog_len_o | output | 8 | Programmed length value (total mod 256) |
| byte_cnt_o | output | 8 | Wrapping byte counter |
| done_o | output | 1 | One-cycle pulse when the last byte is sent |
| err_o | output | 1 | One-cycle pulse on a zero-length start |

## Verification
The bench targets the lengths where the modulo value is 0 (256 and 512). A design that compares the counter without first waiting for bounded mode would either stop after one byte or never stop at all. It also targets 255 and 257, which sit on either side of the mode threshold. An off-by-one in the switch shows up there as `fixed_mode_o` changing one byte early or late. Random lengths up to 1500 with random gaps between strobes, a restart attempted mid-packet, strobes in idle and a zero-length start expose a counter that moves when idle, a done pulse that lasts too long, and a length register that a stray start overwrites.

// File: rtl/pkt_len_pkg.sv
package pkt_len_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } plc_state_e;
endpackage

// File: rtl/plc_byte_ctr.sv
module plc_byte_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);  // natural wrap
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/plc_remain_ctr.sv
module plc_remain_ctr #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic [LEN_W-1:0] remain_o,
  output logic             below_nxt_o  // remaining < wrap after one more decrement
);
  localparam logic [LEN_W-1:0] WRAP = LEN_W'(1) << CNT_W;

  logic [LEN_W-1:0] rem_q;

  assign remain_o    = rem_q;
  assign below_nxt_o = (rem_q <= WRAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= len_i;
    else if (dec_i)  rem_q <= rem_q - LEN_W'(1);
  end
endmodule

// File: rtl/pkt_len_ctrl.sv
module pkt_len_ctrl
  import pkt_len_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic             byte_sent_i,
  output logic             busy_o,
  output logic             fixed_mode_o,
  output logic [CNT_W-1:0] prog_len_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             done_o,
  output logic             err_o
);
  plc_state_e       state_q;
  logic             load, zero_req, step, end_hit;
  logic             fixed_q, done_q, err_q, below_nxt;
  logic [CNT_W-1:0] prog_q, cnt_nxt;
  logic [LEN_W-1:0] remain_q;
  logic             short_len;

  assign short_len = ~|total_len_i[LEN_W-1:CNT_W];
  assign load      = (state_q == ST_IDLE) && start_i && (|total_len_i);
  assign zero_req  = (state_q == ST_IDLE) && start_i && !(|total_len_i);
  assign step      = (state_q == ST_RUN) && byte_sent_i;
  // last byte: only in bounded mode does a counter match mean the end
  assign end_hit   = step && fixed_q && (cnt_nxt == prog_q);

  plc_byte_ctr #(.CNT_W(CNT_W)) u_byte_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .inc_i     (step),
    .cnt_o     (byte_cnt_o),
    .cnt_nxt_o (cnt_nxt)
  );

  plc_remain_ctr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_remain_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .len_i       (total_len_i),
    .dec_i       (step),
    .remain_o    (remain_q),
    .below_nxt_o (below_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fixed_q <= 1'b0;
      prog_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= end_hit;
      err_q  <= zero_req;
      if (load) begin
        state_q <= ST_RUN;
        fixed_q <= short_len;
        prog_q  <= total_len_i[CNT_W-1:0];
      end else if (step) begin
        fixed_q <= fixed_q | below_nxt;
        if (end_hit) state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o       = (state_q == ST_RUN);
  assign fixed_mode_o = fixed_q;
  assign prog_len_o   = prog_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/pkt_len_ctrl_chk.sv
module pkt_len_ctrl_chk #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             byte_sent_i,
  input logic             busy_o,
  input logic             fixed_mode_o,
  input logic [CNT_W-1:0] prog_len_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic             done_o,
  input logic             err_o,
  input logic [LEN_W-1:0] remain_q
);
  localparam logic [LEN_W-1:0] WRAP = LEN_W'(1) << CNT_W;

  assert_cnt_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_sent_i) |=> byte_cnt_o == CNT_W'($past(byte_cnt_o) + CNT_W'(1)));

  assert_mode_thresh_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (fixed_mode_o == (remain_q < WRAP)));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && fixed_mode_o && byte_cnt_o == prog_len_o && remain_q == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(byte_cnt_o) && !done_o && !busy_o));

  assert_zero_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !byte_sent_i) |=> (busy_o && $stable(prog_len_o) && $stable(byte_cnt_o)));

  assert_fixed_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && fixed_mode_o) |=> fixed_mode_o);
endmodule

bind pkt_len_ctrl pkt_len_ctrl_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_pkt_len_ctrl.sv
module sim_pkt_len_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] total_len_i = '0;
  logic        byte_sent_i = 1'b0;
  logic        busy_o, fixed_mode_o, done_o, err_o;
  logic [7:0]  prog_len_o, byte_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  pkt_len_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_prog(input int total);
    return total % 256;
  endfunction

  function automatic bit exp_fixed(input int total, input int sent);
    return (total - sent) < 256;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // send a whole packet; optionally try a restart mid-packet (R9)
  task automatic send_pkt(input int total, input bit restart, input int max_gap);
    int p;
    @(negedge clk_i);
    start_i = 1'b1; total_len_i = 16'(total);
    @(negedge clk_i);
    start_i = 1'b0;
    p = exp_prog(total);
    chk(busy_o == 1'b1, "R2/R3 busy", int'(busy_o), 1);
    if (total < 256) chk(fixed_mode_o == 1'b1, "R2 mode", int'(fixed_mode_o), 1);
    else             chk(fixed_mode_o == 1'b0, "R3 mode", int'(fixed_mode_o), 0);
    chk(int'(prog_len_o) == p, "R2/R3 prog_len", int'(prog_len_o), p);
    chk(byte_cnt_o == 8'd0, "R2/R3 cnt", int'(byte_cnt_o), 0);
    for (int k = 1; k <= total; k++) begin
      int gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
      for (int g = 0; g < gap; g++) @(negedge clk_i);
      if (restart && k == total / 2) begin
        start_i = 1'b1; total_len_i = 16'd7;
      end
      byte_sent_i = 1'b1;
      @(negedge clk_i);
      byte_sent_i = 1'b0; start_i = 1'b0;
      chk(int'(byte_cnt_o) == k % 256, "R4 cnt", int'(byte_cnt_o), k % 256);
      chk(fixed_mode_o == exp_fixed(total, k), "R5/R10 mode", int'(fixed_mode_o),
          int'(exp_fixed(total, k)));
      chk(done_o == (k == total), "R6 done", int'(done_o), int'(k == total));
      chk(busy_o == (k < total), "R6 busy", int'(busy_o), int'(k < total));
      if (restart && k == total / 2)
        chk(int'(prog_len_o) == p, "R9 prog_len kept", int'(prog_len_o), p);
    end
    chk(int'(byte_cnt_o) == p, "R6 cnt==prog", int'(byte_cnt_o), p);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R6 one-cycle done", int'(done_o), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2.5);
    // R1 reset values
    chk(busy_o == 0 && fixed_mode_o == 0 && done_o == 0 && err_o == 0, "R1 flags",
        int'({busy_o, fixed_mode_o, done_o, err_o}), 0);
    chk(prog_len_o == 0 && byte_cnt_o == 0, "R1 values", int'({prog_len_o, byte_cnt_o}), 0);
    rst_ni = 1'b1;

    // R8 zero-length start
    @(negedge clk_i);
    start_i = 1'b1; total_len_i = 16'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8 err pulse", int'(err_o), 1);
    chk(busy_o == 1'b0, "R8 stays idle", int'(busy_o), 0);
    @(negedge clk_i);
    chk(err_o == 1'b0, "R8 err one cycle", int'(err_o), 0);

    // directed corners
    send_pkt(600, 1'b0, 0);
    send_pkt(256, 1'b0, 1);
    send_pkt(512, 1'b0, 0);
    send_pkt(1, 1'b0, 0);
    send_pkt(255, 1'b0, 0);
    send_pkt(257, 1'b0, 2);
    send_pkt(300, 1'b1, 1);

    // R7 idle strobes ignored
    for (int i = 0; i < 4; i++) begin
      byte_sent_i = 1'b1;
      @(negedge clk_i);
      byte_sent_i = 1'b0;
      chk(int'(byte_cnt_o) == 300 % 256, "R7 cnt hold", int'(byte_cnt_o), 300 % 256);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R7 no done", int'({done_o, busy_o}), 0);
    end

    // random lengths
    for (int i = 0; i < 8; i++) begin
      int len = int'($urandom_range(1500, 1));
      send_pkt(len, i[0], 2);
    end

    finish_run();
  end
endmodule